// File: doc/BRIEF.md
# Infrared Receive Byte Queue with Event Flags

This block sits between an infrared sampler and the processor bus. Every run-length byte the sampler produces is stored in a first-in first-out queue. Software drains the queue through a register read port. The queue depth is a parameter. The two intended builds use 16 and 64 entries, and either depth must be a power of two.

Three events are recorded in a flag register:
- a fill-level event, raised while the queue holds more entries than a programmed level;
- a packet-end event, raised by an idle pulse from the sampler;
- an overflow event, raised when an incoming byte has to be discarded because the queue is full.

A mask register selects which flags drive the single interrupt line. Flags are cleared by writing ones to them. The flag word also carries the live fill count, so one read tells the handler both why it was interrupted and how many bytes to pull.

Register access is a simple select/strobe port with combinational read data. A read strobe on the data register removes the oldest byte.

Top module: `ir_rx_queue`

## Requirements
- R1: After synchronous reset the queue is empty, all flags and mask bits are zero, the level field is zero and `irq` is low.
- R2: A read strobe with select 0 (data) returns the oldest queued byte in bits 7:0, with bits 31:8 zero, and removes that byte; bytes come out in arrival order.
- R3: Reading select 0 while the queue is empty returns zero and changes nothing.
- R4: Select 2 (flags) returns the current fill count in bits starting at 8, in a field of log2(DEPTH)+1 bits.
- R5: A byte that arrives while the queue holds DEPTH entries, with no removal in the same cycle, is discarded, and flag bit 0 (overflow) is set on the next clock.
- R6: When the queue is full, a byte that arrives in the same cycle as a removal is accepted, and no overflow is flagged.
- R7: A packet-end pulse sets flag bit 1 on the next clock.
- R8: Flag bit 4 (fill level) is set on the clock after the fill count exceeds the level field, which sits in bits starting at 8 of select 1 (mask).
- R9: Writing select 2 clears every flag whose write-data bit is one; writing 0xFF clears all flags; zero bits leave flags unchanged.
- R10: A raising event in the same cycle as a clear of the same flag leaves the flag set.
- R11: `irq` is high exactly when some flag is set and its mask bit (0, 1 or 4 of select 1) is set.
- R12: Select 1 reads back only mask bits 0, 1 and 4 and the level field; all other bits read zero. Select 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sampler byte strobe |
| smp_byte | input | 8 | Run-length byte from sampler |
| pkt_idle | input | 1 | Packet-end pulse from idle detector |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (removes a byte when select is 0) |
| reg_sel | input | 2 | Register select: 0 data, 1 mask, 2 flags, 3 unused |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from select |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted pointer or counter appears on the very next read of the data register as a wrong or reordered byte. It also shows in the flags word, whose count field would then disagree with the number of pushes and pops. A flag held in the wrong state shows in the same cycle on `irq` when it is masked in, and it shows in the flags word on every read. The level comparison and the clear-versus-raise priority are compared against a queue model on every clock, so an off-by-one in either shows within one cycle of the boundary being crossed.

// File: rtl/ir_rx_queue_pkg.sv
package ir_rx_queue_pkg;

    // Flag bit positions shared by the mask and flag words
    localparam int FLAG_OVF  = 0;
    localparam int FLAG_PKT  = 1;
    localparam int FLAG_AVL  = 4;
    // Lowest bit of the count / level field
    localparam int FIELD_LSB = 8;

    typedef enum logic [1:0] {
        SEL_DATA   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic avail;
        logic pkt;
        logic ovf;
    } evt_t;

    function automatic logic [7:0] evt_to_byte(evt_t e);
        logic [7:0] b;
        b = '0;
        b[FLAG_OVF] = e.ovf;
        b[FLAG_PKT] = e.pkt;
        b[FLAG_AVL] = e.avail;
        return b;
    endfunction

    function automatic evt_t byte_to_evt(logic [7:0] b);
        evt_t e;
        e.ovf   = b[FLAG_OVF];
        e.pkt   = b[FLAG_PKT];
        e.avail = b[FLAG_AVL];
        return e;
    endfunction

endpackage

// File: rtl/irrxq_store.sv
module irrxq_store #(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push_req,
    input  logic [7:0]                 push_byte,
    input  logic                       pop_req,
    output logic [7:0]                 head_byte,
    output logic [$clog2(DEPTH):0]     fill,
    output logic                       dropped
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [7:0]    slots [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] cnt;
    logic          full;
    logic          pop_do;
    logic          push_do;

    assign full    = (cnt == CW'(DEPTH));
    assign pop_do  = pop_req && (cnt != '0);
    // A removal in the same cycle frees a slot for the arriving byte
    assign push_do = push_req && (!full || pop_do);
    assign dropped = push_req && !push_do;

    always_ff @(posedge clk) begin
        if (push_do) begin
            slots[wr_ptr] <= push_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_do) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop_do) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            case ({push_do, pop_do})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head_byte = slots[rd_ptr];
    assign fill      = cnt;

endmodule

// File: rtl/irrxq_flags.sv
module irrxq_flags
    import ir_rx_queue_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t raise,
    input  evt_t clear,
    output evt_t held
);
    // Raising wins over clearing in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else begin
            held <= (held & ~clear) | raise;
        end
    end

endmodule

// File: rtl/irrxq_regs.sv
module irrxq_regs
    import ir_rx_queue_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [1:0]                 reg_sel,
    input  logic [31:0]                reg_wdata,
    input  evt_t                       held,
    input  logic [$clog2(DEPTH):0]     fill,
    input  logic [7:0]                 head_byte,
    output logic [31:0]                reg_rdata,
    output logic                       irq,
    output logic [$clog2(DEPTH):0]     level,
    output evt_t                       clear_req,
    output logic                       pop_req
);
    localparam int CW = $clog2(DEPTH) + 1;

    reg_sel_e sel;
    evt_t     mask_q;

    assign sel = reg_sel_e'(reg_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            level  <= '0;
        end else if (reg_wr && sel == SEL_ENABLE) begin
            mask_q <= byte_to_evt(reg_wdata[7:0]);
            level  <= reg_wdata[FIELD_LSB +: CW];
        end
    end

    assign clear_req = (reg_wr && sel == SEL_STATUS) ? byte_to_evt(reg_wdata[7:0]) : '0;
    assign pop_req   = reg_rd && sel == SEL_DATA;
    assign irq       = |(mask_q & held);

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_DATA: begin
                if (fill != '0) begin
                    reg_rdata[7:0] = head_byte;
                end
            end
            SEL_ENABLE: begin
                reg_rdata[7:0]              = evt_to_byte(mask_q);
                reg_rdata[FIELD_LSB +: CW]  = level;
            end
            SEL_STATUS: begin
                reg_rdata[7:0]              = evt_to_byte(held);
                reg_rdata[FIELD_LSB +: CW]  = fill;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ir_rx_queue.sv
module ir_rx_queue
    import ir_rx_queue_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        smp_valid,
    input  logic [7:0]  smp_byte,
    input  logic        pkt_idle,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [CW-1:0] fill_cnt;
    logic [CW-1:0] level;
    logic [7:0]    head_byte;
    logic          dropped;
    logic          pop_req;
    evt_t          raise;
    evt_t          clear_req;
    evt_t          held;
    logic [7:0]    flag_bits;

    irrxq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push_req  (smp_valid),
        .push_byte (smp_byte),
        .pop_req   (pop_req),
        .head_byte (head_byte),
        .fill      (fill_cnt),
        .dropped   (dropped)
    );

    always_comb begin
        raise.ovf   = dropped;
        raise.pkt   = pkt_idle;
        raise.avail = (fill_cnt > level);
    end

    irrxq_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .raise (raise),
        .clear (clear_req),
        .held  (held)
    );

    irrxq_regs #(.DEPTH(DEPTH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .held      (held),
        .fill      (fill_cnt),
        .head_byte (head_byte),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .level     (level),
        .clear_req (clear_req),
        .pop_req   (pop_req)
    );

    assign flag_bits = evt_to_byte(held);

endmodule

// File: rtl/irrxq_chk.sv
module irrxq_chk
    import ir_rx_queue_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   smp_valid,
    input logic                   pkt_idle,
    input logic                   reg_wr,
    input logic                   reg_rd,
    input logic [1:0]             reg_sel,
    input logic [31:0]            reg_wdata,
    input logic                   irq,
    input logic [$clog2(DEPTH):0] fill_cnt,
    input logic [7:0]             flag_bits
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic rd_data;
    logic wr_flags;
    assign rd_data  = reg_rd && (reg_sel == SEL_DATA);
    assign wr_flags = reg_wr && (reg_sel == SEL_STATUS);

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill_cnt <= CW'(DEPTH));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && fill_cnt == CW'(DEPTH) && !rd_data)
        |=> (fill_cnt == CW'(DEPTH) && flag_bits[FLAG_OVF]));

    // R2
    pop_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data && fill_cnt != '0 && !smp_valid)
        |=> (fill_cnt == $past(fill_cnt) - 1'b1));

    // R7
    pkt_flag_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_idle |=> flag_bits[FLAG_PKT]);

    // R10
    raise_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_idle && wr_flags && reg_wdata[FLAG_PKT]) |=> flag_bits[FLAG_PKT]);

    // R9
    pkt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_flags && reg_wdata[FLAG_PKT] && !pkt_idle) |=> !flag_bits[FLAG_PKT]);

    // R11
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag_bits != 8'h00));

endmodule

bind ir_rx_queue irrxq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .pkt_idle  (pkt_idle),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .fill_cnt  (fill_cnt),
    .flag_bits (flag_bits)
);

// File: tb/sim_ir_rx_queue.sv
module sim_ir_rx_queue;
    localparam int DEPTH = 16;
    localparam int CW    = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [7:0]  smp_byte = '0;
    logic        pkt_idle = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    always #5 clk = ~clk;

    ir_rx_queue #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_byte(smp_byte),
        .pkt_idle(pkt_idle), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    string tag     = "R1";
    bit    done    = 1'b0;

    // Behavioural reference model
    logic [7:0]    mq[$];
    logic [7:0]    m_st  = '0;
    logic [7:0]    m_en  = '0;
    logic [CW-1:0] m_lvl = '0;

    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            m_st  = '0;
            m_en  = '0;
            m_lvl = '0;
        end else begin
            int  psz;
            bit  pop, push_ok, ovf, avl;
            logic [7:0] clr;
            psz     = mq.size();
            pop     = reg_rd && reg_sel == 2'd0 && psz > 0;
            push_ok = smp_valid && (psz < DEPTH || pop);
            ovf     = smp_valid && !push_ok;
            avl     = psz > int'(m_lvl);
            clr     = (reg_wr && reg_sel == 2'd2) ? (reg_wdata[7:0] & 8'h13) : 8'h00;
            m_st    = (m_st & ~clr) | {3'b000, avl, 2'b00, 1'b0, ovf} | {6'b0, pkt_idle, 1'b0};
            if (reg_wr && reg_sel == 2'd1) begin
                m_en  = reg_wdata[7:0] & 8'h13;
                m_lvl = reg_wdata[8 +: CW];
            end
            if (pop) void'(mq.pop_front());
            if (push_ok) mq.push_back(smp_byte);
        end
    end

    function automatic logic [31:0] m_rdata();
        logic [31:0] r;
        r = '0;
        case (reg_sel)
            2'd0: if (mq.size() > 0) r[7:0] = mq[0];
            2'd1: begin r[7:0] = m_en; r[8 +: CW] = m_lvl; end
            2'd2: begin r[7:0] = m_st; r[8 +: CW] = CW'(mq.size()); end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic compare();
        logic [31:0] exp_d;
        logic        exp_i;
        exp_d = m_rdata();
        exp_i = |(m_st & m_en);
        n_tests++;
        if (reg_rdata !== exp_d) begin
            n_fail++;
            $display("FAIL %s sel=%0d rdata actual=%h expected=%h", tag, reg_sel, reg_rdata, exp_d);
        end
        n_tests++;
        if (irq !== exp_i) begin
            n_fail++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp_i);
        end
    endtask

    task automatic tick(input bit wr, input bit rd, input logic [1:0] sel,
                        input logic [31:0] wd, input bit iv, input logic [7:0] ib,
                        input bit pe);
        reg_wr = wr; reg_rd = rd; reg_sel = sel; reg_wdata = wd;
        smp_valid = iv; smp_byte = ib; pkt_idle = pe;
        #1 compare();
        @(negedge clk);
    endtask

    task automatic t_idle(input logic [1:0] sel);
        tick(0, 0, sel, 32'h0, 0, 8'h00, 0);
    endtask
    task automatic t_push(input logic [7:0] b);
        tick(0, 0, 2'd2, 32'h0, 1, b, 0);
    endtask
    task automatic t_pop();
        tick(0, 1, 2'd0, 32'h0, 0, 8'h00, 0);
    endtask
    task automatic t_wr(input logic [1:0] sel, input logic [31:0] wd);
        tick(1, 0, sel, wd, 0, 8'h00, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        tag = "R1";
        t_idle(2'd2); t_idle(2'd1); t_idle(2'd0);
        // R12 mask readback
        tag = "R12";
        t_wr(2'd1, 32'hFFFF_FFFF); t_idle(2'd1); t_idle(2'd3);
        t_wr(2'd1, 32'h0); t_idle(2'd1);
        // R3 empty read
        tag = "R3";
        t_pop(); t_pop(); t_idle(2'd2);
        // R2 ordering, R4 count
        tag = "R2";
        for (int i = 0; i < 5; i++) t_push(8'hA0 + 8'(i));
        tag = "R4";
        t_idle(2'd2);
        tag = "R2";
        for (int i = 0; i < 5; i++) t_pop();
        t_idle(2'd2);
        // R8 fill-level threshold = 7
        tag = "R8";
        t_wr(2'd1, 32'h0000_0710);
        for (int i = 0; i < 7; i++) t_push(8'h10 + 8'(i));
        t_idle(2'd2); t_idle(2'd2);
        t_push(8'h17);
        t_idle(2'd2); t_idle(2'd2);
        // R10 clear while condition persists
        tag = "R10";
        t_wr(2'd2, 32'h0000_00FF); t_idle(2'd2);
        // R9 clear after condition ends; zero write has no effect
        tag = "R9";
        t_pop(); t_idle(2'd2);
        t_wr(2'd2, 32'h0000_00FF); t_idle(2'd2);
        tick(0, 0, 2'd2, 32'h0, 0, 8'h00, 1);
        t_wr(2'd2, 32'h0); t_idle(2'd2);
        t_wr(2'd2, 32'h0000_0002); t_idle(2'd2);
        // R7 packet end
        tag = "R7";
        tick(0, 0, 2'd2, 32'h0, 0, 8'h00, 1); t_idle(2'd2);
        // R10 packet end with clear in same cycle
        tag = "R10";
        tick(1, 0, 2'd2, 32'h0000_0002, 0, 8'h00, 1); t_idle(2'd2);
        // R11 interrupt gating
        tag = "R11";
        t_wr(2'd1, 32'h0000_1F02); t_idle(2'd2);
        t_wr(2'd2, 32'h0000_0002); t_idle(2'd2);
        t_wr(2'd1, 32'h0000_1F00);
        tick(0, 0, 2'd2, 32'h0, 0, 8'h00, 1); t_idle(2'd2);
        // R5 overflow: fill 7 -> 16, then drop three
        tag = "R5";
        for (int i = 0; i < 9; i++) t_push(8'h30 + 8'(i));
        t_idle(2'd2);
        for (int i = 0; i < 3; i++) t_push(8'hE0 + 8'(i));
        t_idle(2'd2);
        t_wr(2'd1, 32'h0000_1F01); t_idle(2'd2);
        // R6 full with push and pop together
        tag = "R6";
        t_wr(2'd2, 32'h0000_00FF);
        tick(0, 1, 2'd0, 32'h0, 1, 8'h5A, 0);
        t_idle(2'd2); t_idle(2'd2);
        // R2 drain all, order excludes dropped bytes
        tag = "R2";
        for (int i = 0; i < DEPTH; i++) t_pop();
        t_idle(2'd2); t_pop();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule